// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short shift register with the outcomes of the most recent resolved branches. That history value picks one of several banks of 2-bit saturating counters. A slice of the lookup pc then picks one counter inside the chosen bank, and the counter's upper bit is the prediction. Branches that depend on the results of nearby earlier branches can therefore use separate counters for each recent outcome pattern.

A front-end stage presents a pc on the lookup port and gets a taken/not-taken answer in the same cycle. When a branch resolves later in the pipeline, its pc and outcome arrive on the training port. The counter that this branch would have used is moved one step toward the outcome. The outcome is then shifted into the history. The history changes only on training, never at lookup.

Top module: `dir_pred_2lvl`

## Requirements
- R1: After reset the history is all zero and every counter holds 2'b01 (weakly not taken), so every lookup predicts not taken.
- R2: The prediction is the upper bit of the counter at bank `hist`, entry `pc[IDX_W+1:2]`. It is combinational from the current state and the lookup pc.
- R3: Lookup pc bits [1:0] and bits above IDX_W+1 have no effect on the prediction.
- R4: A taken training adds one to the selected counter and saturates at 2'b11.
- R5: A not-taken training subtracts one from the selected counter and saturates at 2'b00.
- R6: Training updates the counter indexed by the history value before the shift. The new history is `{old_hist[HIST_W-2:0], taken}`, so bit 0 holds the newest outcome.
- R7: With `trn_valid` low, neither the history nor any counter changes, whatever the lookup port does.
- R8: When a lookup and a training hit the same entry in one cycle, the prediction reflects the state before the training. The update is visible from the next clock.
- R9: Each training changes exactly one counter.
- R10: Starting from strongly taken, a single not-taken outcome leaves the prediction taken, and a second one flips it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_pc | input | PC_W | Pc to predict |
| lkp_taken | output | 1 | Predicted direction, 1 = taken |
| trn_valid | input | 1 | A resolved branch is presented for training |
| trn_pc | input | PC_W | Pc of the resolved branch |
| trn_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
Lookup and training can land in the same cycle, on the same counter. The bench drives every training with the lookup pc equal to the training pc. It compares that cycle's prediction with the reference model's pre-update state, then sweeps the current bank after the edge to see the update. A long pseudo-random training stream, with bank sweeps interleaved, confirms that each update reached only its own entry in the bank named by the old history.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  // Saturating step toward the resolved outcome.
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == 2'b11) ? c : ctr_t'(c + 2'd1);
    else       r = (c == 2'b00) ? c : ctr_t'(c - 2'd1);
    return r;
  endfunction

  function automatic logic ctr_dir(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/hist_shift.sv
module hist_shift #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_in,
  output logic [HIST_W-1:0] hist_q
);
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      assign hist_d = shift_in;
    end else begin : g_many
      assign hist_d = {hist_q[HIST_W-2:0], shift_in};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end
endmodule

// File: rtl/ctr_bank.sv
module ctr_bank
  import bp_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t cells [DEPTH];

  assign rd_ctr = cells[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      cells[wr_idx] <= ctr_step(cells[wr_idx], wr_taken);
    end
  end
endmodule

// File: rtl/dir_pred_2lvl.sv
module dir_pred_2lvl
  import bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lkp_pc,
  output logic            lkp_taken,
  input  logic            trn_valid,
  input  logic [PC_W-1:0] trn_pc,
  input  logic            trn_taken
);
  localparam int NBANK = 1 << HIST_W;
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [HIST_W-1:0] hist_q;
  logic [IDX_W-1:0]  lkp_idx;
  logic [IDX_W-1:0]  trn_idx;
  logic [NBANK-1:0]  bank_we;
  ctr_t              bank_rd [NBANK];
  ctr_t              sel_ctr;

  assign lkp_idx = lkp_pc[IDX_HI:IDX_LO];
  assign trn_idx = trn_pc[IDX_HI:IDX_LO];

  wire unused_pc_bits = ^{lkp_pc[IDX_LO-1:0], lkp_pc[PC_W-1:IDX_HI+1],
                          trn_pc[IDX_LO-1:0], trn_pc[PC_W-1:IDX_HI+1]};

  hist_shift #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (trn_valid),
    .shift_in (trn_taken),
    .hist_q   (hist_q)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bank_we[b] = trn_valid && (hist_q == HIST_W'(b));
      ctr_bank #(.IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lkp_idx),
        .rd_ctr   (bank_rd[b]),
        .wr_en    (bank_we[b]),
        .wr_idx   (trn_idx),
        .wr_taken (trn_taken)
      );
    end
  endgenerate

  assign sel_ctr   = bank_rd[hist_q];
  assign lkp_taken = ctr_dir(sel_ctr);
endmodule

// File: rtl/dir_pred_chk.sv
module dir_pred_chk #(
  parameter int HIST_W = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    trn_valid,
  input logic                    trn_taken,
  input logic [HIST_W-1:0]       hist_q,
  input logic [(1<<HIST_W)-1:0]  bank_we
);
  // R1
  hist_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> hist_q == '0);

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trn_valid |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(trn_taken)});

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trn_valid |=> $stable(hist_q));

  // R7
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trn_valid |-> bank_we == '0);

  // R9
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trn_valid |-> $countones(bank_we) == 1);
endmodule

bind dir_pred_2lvl dir_pred_chk #(.HIST_W(HIST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trn_valid (trn_valid),
  .trn_taken (trn_taken),
  .hist_q    (hist_q),
  .bank_we   (bank_we)
);

// File: tb/sim_dir_pred_2lvl.sv
module sim_dir_pred_2lvl;
  localparam int PC_W = 32;
  localparam int IDX_W = 4;
  localparam int HIST_W = 2;
  localparam int NB = 1 << HIST_W;
  localparam int NE = 1 << IDX_W;

  logic clk = 0;
  logic rst_n = 0;
  logic [PC_W-1:0] lkp_pc = '0;
  logic lkp_taken;
  logic trn_valid = 0;
  logic [PC_W-1:0] trn_pc = '0;
  logic trn_taken = 0;

  int total = 0;
  int bad = 0;
  int model [NB][NE];
  int mhist = 0;
  logic [31:0] rs = 32'h1234_5678;

  always #4 clk = ~clk;

  dir_pred_2lvl #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u0 (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(lkp_taken),
    .trn_valid(trn_valid), .trn_pc(trn_pc), .trn_taken(trn_taken));

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s pc=%h hist=%0d got=%0b exp=%0b", req, lkp_pc, mhist, got, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] mkpc(input int idx, input logic [31:0] r);
    return {r[31:IDX_W+2], IDX_W'(idx), r[1:0]};
  endfunction

  function automatic logic mpred(input logic [PC_W-1:0] pc);
    return model[mhist][pc[IDX_W+1:2]] >= 2;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  // Train one branch; lookup the same pc in the same cycle (R8).
  task automatic train(input logic [PC_W-1:0] pc, input logic t, input string req);
    int i;
    @(negedge clk);
    trn_valid = 1; trn_pc = pc; trn_taken = t; lkp_pc = pc;
    #1 chk(req, lkp_taken, mpred(pc));
    @(posedge clk);
    #1;
    trn_valid = 0;
    i = pc[IDX_W+1:2];
    if (t) model[mhist][i] = (model[mhist][i] == 3) ? 3 : model[mhist][i] + 1;
    else   model[mhist][i] = (model[mhist][i] == 0) ? 0 : model[mhist][i] - 1;
    mhist = ((mhist << 1) | int'(t)) & (NB - 1);
  endtask

  // Sweep all entries of the current bank without training.
  task automatic sweep(input string req);
    for (int e = 0; e < NE; e++) begin
      @(negedge clk);
      rs = nxt(rs);
      lkp_pc = mkpc(e, rs);
      #1 chk(req, lkp_taken, mpred(lkp_pc));
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input logic exp, input string req);
    @(negedge clk);
    lkp_pc = pc;
    #1 chk(req, lkp_taken, exp);
  endtask

  initial begin
    #(8 * 190000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] p, q;
    for (int b = 0; b < NB; b++)
      for (int e = 0; e < NE; e++) model[b][e] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state, every entry in bank 0 predicts not taken
    for (int e = 0; e < NE; e++) look(mkpc(e, 32'hA5A5_0000 + e), 1'b0, "R1");

    p = mkpc(5, 32'h0);
    q = mkpc(9, 32'h0);
    // R5: repeated not-taken at hist 0 saturates at 0 (pre-checks catch wrap)
    repeat (5) train(p, 1'b0, "R5");
    look(p, 1'b0, "R5");
    // R4/R10: drive bank 3 entry of p to strongly taken, then hysteresis
    train(q, 1'b1, "R6");
    train(q, 1'b1, "R6");
    repeat (5) train(p, 1'b1, "R4");
    train(p, 1'b0, "R10");
    train(q, 1'b1, "R6");
    train(q, 1'b1, "R6");
    look(p, 1'b1, "R10");
    train(p, 1'b0, "R10");
    train(q, 1'b1, "R6");
    train(q, 1'b1, "R6");
    look(p, 1'b0, "R10");

    // R3: pc bits outside the index field ignored
    for (int e = 0; e < NE; e++) begin
      look(mkpc(e, 32'h0), mpred(mkpc(e, 32'h0)), "R3");
      look(mkpc(e, 32'hFFFF_FFFF), mpred(mkpc(e, 32'h0)), "R3");
    end

    // R7: lookups alone leave state unchanged
    repeat (3) sweep("R7");

    // R2/R6/R8/R9: pseudo-random training stream with bank sweeps
    for (int n = 0; n < 3000; n++) begin
      rs = nxt(rs);
      train(mkpc(int'(rs[7:4]) & (NE - 1), nxt(rs)), rs[9] ^ (rs[3] & rs[11]), "R8");
      if (n % 40 == 39) sweep("R9");
    end
    for (int k = 0; k < NB; k++) begin
      sweep("R2");
      train(q, k[0], "R6");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule